// File: doc/BRIEF.md
# Processor Status Register

This block is the status register of a small processor core. It stores three arithmetic flags (zero, digit carry, carry) and two reset-status bits (time-out and power-down), and presents them as one status byte. The core's execute stage drives it with the instruction's direct write to the register and with the flag results of the ALU. Each ALU flag has its own update enable.

When one instruction both targets the status register and changes any arithmetic flag, the hardware flags take priority. The direct write is then dropped for all three arithmetic bits. Flags with an update enable take the ALU value, and the other arithmetic bits keep their value. Software cannot change the time-out and power-down bits. Only four event strobes change them: power-up, watchdog time-out, sleep entry and watchdog clear.

The status byte is registered. Every change shows on the output one clock after the edge that samples the inputs.

Top module: `proc_status_reg`

## Requirements
- R1: Bits 7 to 5 of `status_o` always read 0, whatever value is written to them.
- R2: After reset, `status_o` is 8'h18: time-out = 1, power-down = 1, and Z, DC and C = 0.
- R3: Bit positions are carry = bit 0, digit carry = bit 1, zero = bit 2, power-down = bit 3 and time-out = bit 4. The index of `alu_flags` and `flag_upd` matches: 0 = C, 1 = DC, 2 = Z.
- R4: A flag whose `flag_upd` bit is 1 holds the matching `alu_flags` bit after the next edge, whether or not `wr_en` is high.
- R5: When `wr_en` is 1 and `flag_upd` is 0, bits 2..0 take `wr_data[2:0]`. Bit set and bit clear are plain writes of this kind.
- R6: An arithmetic flag without its update enable keeps its value when `wr_en` is 0, or when any other flag is being updated in the same cycle.
- R7: A write never changes the time-out or power-down bits.
- R8: `ev_pwrup` sets both time-out and power-down, and overrides every other event.
- R9: Without power-up, `ev_wdt_to` clears time-out and leaves power-down alone.
- R10: Without power-up, `ev_sleep` clears power-down. It also sets time-out, unless a watchdog time-out arrives in the same cycle.
- R11: Without a higher-priority event, `ev_wdt_clr` sets both time-out and power-down.
- R12: A clear instruction (write 8'h00, Z updated to 1, DC and C not updated) leaves bits 7..5 = 0 and Z = 1, with DC, C, time-out and power-down unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Instruction writes the status register |
| wr_data | input | 8 | Data of the direct write |
| alu_flags | input | 3 | ALU results {Z, DC, C} |
| flag_upd | input | 3 | Per-flag update enables {Z, DC, C} |
| ev_pwrup | input | 1 | Power-up event strobe |
| ev_wdt_to | input | 1 | Watchdog time-out strobe |
| ev_sleep | input | 1 | Sleep-entry strobe |
| ev_wdt_clr | input | 1 | Watchdog-clear strobe |
| status_o | output | 8 | Registered status byte |

## Verification
Every result of this block is due exactly one clock edge after its stimulus: flag merges, write blocking and event effects alike. No stage in the path is combinational to the output. The bench changes inputs on the falling edge and compares `status_o` on the following falling edge, just after the single register update. The flag sweep and the event sweep each carry a model of the expected state that advances by one step per check. Every comparison is therefore against the value due for that step.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   // Bit positions inside the status byte; other logic decodes them.
   localparam int unsigned POS_C  = 0;
   localparam int unsigned POS_DC = 1;
   localparam int unsigned POS_Z  = 2;
   localparam int unsigned POS_PD = 3;
   localparam int unsigned POS_TO = 4;
   localparam int unsigned NFLAG  = 3;
   localparam int unsigned MIN_W  = 5;

   typedef struct packed {
      logic pwrup;
      logic wdt_to;
      logic sleep;
      logic wdt_clr;
   } sreg_evt_t;
endpackage

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge #(
   parameter int unsigned NF = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [NF-1:0] wr_bits,
   input  logic [NF-1:0] alu_val,
   input  logic [NF-1:0] upd,
   output logic [NF-1:0] flags
);
   initial assert (NF >= 1) else $error("sreg_flag_merge: NF must be at least 1");

   // Any hardware flag update blocks the direct write to every arithmetic bit.
   logic any_upd;
   logic wr_pass;
   assign any_upd = |upd;
   assign wr_pass = wr_en & ~any_upd;

   for (genvar i = 0; i < NF; i++) begin : g_flag
      logic nxt;
      always_comb begin
         if (upd[i])       nxt = alu_val[i];
         else if (wr_pass) nxt = wr_bits[i];
         else              nxt = flags[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= nxt;
      end

      assert_alu_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         upd[i] |=> flags[i] == $past(alu_val[i]));
      assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && upd == '0) |=> flags[i] == $past(wr_bits[i]));
      assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!upd[i] && (!wr_en || upd != '0)) |=> $stable(flags[i]));
   end
endmodule

// File: rtl/sreg_rst_status.sv
module sreg_rst_status
   import sreg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  sreg_evt_t evt,
   output logic      to_bit,
   output logic      pd_bit
);
   // Priority for time-out: power-up, then watchdog time-out, then sleep / watchdog clear.
   // Priority for power-down: power-up, then sleep, then watchdog clear.
   logic to_nxt;
   logic pd_nxt;

   always_comb begin
      if (evt.pwrup)                       to_nxt = 1'b1;
      else if (evt.wdt_to)                 to_nxt = 1'b0;
      else if (evt.sleep || evt.wdt_clr)   to_nxt = 1'b1;
      else                                 to_nxt = to_bit;

      if (evt.pwrup)                       pd_nxt = 1'b1;
      else if (evt.sleep)                  pd_nxt = 1'b0;
      else if (evt.wdt_clr)                pd_nxt = 1'b1;
      else                                 pd_nxt = pd_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         to_bit <= 1'b1;
         pd_bit <= 1'b1;
      end else begin
         to_bit <= to_nxt;
         pd_bit <= pd_nxt;
      end
   end

   assert_pwrup_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt.pwrup |=> (to_bit && pd_bit));
   assert_wdt_to_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.wdt_to && !evt.pwrup) |=> !to_bit);
   assert_sleep_clears_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.sleep && !evt.pwrup) |=> !pd_bit);
   assert_quiet_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == '0) |=> ($stable(to_bit) && $stable(pd_bit)));
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
   import sreg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        alu_flags,
   input  logic [2:0]        flag_upd,
   input  logic              ev_pwrup,
   input  logic              ev_wdt_to,
   input  logic              ev_sleep,
   input  logic              ev_wdt_clr,
   output logic [DATA_W-1:0] status_o
);
   localparam int unsigned PAD_W = DATA_W - MIN_W;

   initial assert (DATA_W >= MIN_W) else $error("proc_status_reg: DATA_W below 5");

   logic [NFLAG-1:0] flags;
   logic             to_bit;
   logic             pd_bit;
   sreg_evt_t        evt;

   assign evt = '{pwrup: ev_pwrup, wdt_to: ev_wdt_to, sleep: ev_sleep, wdt_clr: ev_wdt_clr};

   sreg_flag_merge #(.NF(NFLAG)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bits (wr_data[NFLAG-1:0]),
      .alu_val (alu_flags),
      .upd     (flag_upd),
      .flags   (flags)
   );

   sreg_rst_status u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .to_bit (to_bit),
      .pd_bit (pd_bit)
   );

   assign status_o[POS_C]  = flags[POS_C];
   assign status_o[POS_DC] = flags[POS_DC];
   assign status_o[POS_Z]  = flags[POS_Z];
   assign status_o[POS_PD] = pd_bit;
   assign status_o[POS_TO] = to_bit;

   if (PAD_W > 0) begin : g_pad
      assign status_o[DATA_W-1:MIN_W] = '0;
   end

   if (PAD_W > 0) begin : g_pad_chk
      assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
         status_o[DATA_W-1:MIN_W] == '0);
   end
   assert_write_no_rst_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ev_pwrup && !ev_wdt_to && !ev_sleep && !ev_wdt_clr)
      |=> (status_o[POS_TO] == $past(status_o[POS_TO]) &&
           status_o[POS_PD] == $past(status_o[POS_PD])));
endmodule

// File: tb/sim_proc_status_reg.sv
module sim_proc_status_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] alu_flags = '0;
   logic [2:0] flag_upd = '0;
   logic       ev_pwrup = 1'b0, ev_wdt_to = 1'b0, ev_sleep = 1'b0, ev_wdt_clr = 1'b0;
   logic [7:0] status_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model
   logic [2:0] m_f = '0;
   logic       m_to = 1'b1, m_pd = 1'b1;

   always #10 clk = ~clk; // 50 MHz

   proc_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .alu_flags(alu_flags), .flag_upd(flag_upd),
      .ev_pwrup(ev_pwrup), .ev_wdt_to(ev_wdt_to), .ev_sleep(ev_sleep),
      .ev_wdt_clr(ev_wdt_clr), .status_o(status_o)
   );

   function automatic logic [7:0] exp_byte();
      return {3'b000, m_to, m_pd, m_f};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: status actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Model of one clock step, from the requirements.
   task automatic model_step();
      for (int i = 0; i < 3; i++) begin
         if (flag_upd[i])                    m_f[i] = alu_flags[i];
         else if (wr_en && flag_upd == 3'b0) m_f[i] = wr_data[i];
      end
      if (ev_pwrup) begin m_to = 1'b1; m_pd = 1'b1; end
      else begin
         if (ev_wdt_to)                    m_to = 1'b0;
         else if (ev_sleep || ev_wdt_clr)  m_to = 1'b1;
         if (ev_sleep)                     m_pd = 1'b0;
         else if (ev_wdt_clr)              m_pd = 1'b1;
      end
   endtask

   task automatic step();
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      wr_en = 0; flag_upd = 0; alu_flags = 0; wr_data = 0;
      ev_pwrup = 0; ev_wdt_to = 0; ev_sleep = 0; ev_wdt_clr = 0;
   endtask

   task automatic evt(input logic [3:0] e);
      idle();
      {ev_wdt_clr, ev_sleep, ev_wdt_to, ev_pwrup} = e;
      step();
      idle();
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R2 reset value", status_o, 8'h18);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 after release", status_o, 8'h18);

      // R3: field positions via plain write
      idle(); wr_en = 1; wr_data = 8'h05; step(); idle();
      check("R3 C at bit0 Z at bit2", status_o, 8'h1D);
      wr_en = 1; wr_data = 8'h02; step(); idle();
      check("R3 DC at bit1", status_o, 8'h1A);

      // Flag sweep: write enable x update enables x ALU values x write data.
      for (int w = 0; w < 2; w++)
         for (int u = 0; u < 8; u++)
            for (int a = 0; a < 8; a++)
               for (int d = 0; d < 8; d++) begin
                  string tg;
                  logic [7:0] e;
                  wr_en = w[0]; flag_upd = u[2:0]; alu_flags = a[2:0];
                  wr_data = {d[2:0], 2'b11, d[2:0]};
                  if (u != 0)      tg = "R4 R6 alu priority";
                  else if (w != 0) tg = "R5 write lands";
                  else             tg = "R6 hold";
                  step();
                  e = exp_byte();
                  check(tg, status_o, e);
                  check("R1 upper zero", {status_o[7:5], 5'b0}, 8'h00);
                  check("R7 rst bits untouched", {3'b0, status_o[4:3], 3'b0}, {3'b0, e[4:3], 3'b0});
               end
      idle();

      // R12: clear instruction
      wr_en = 1; wr_data = 8'h1B; step(); idle();
      check("R12 preset", status_o, 8'h1B);
      wr_en = 1; wr_data = 8'h00; flag_upd = 3'b100; alu_flags = 3'b100; step(); idle();
      check("R12 clear keeps DC C sets Z", status_o, 8'h1F);

      // Event sweep: four starting states of TO/PD x sixteen event combinations,
      // with a concurrent software write of all ones.
      for (int p = 0; p < 4; p++)
         for (int e = 0; e < 16; e++) begin
            string tg;
            evt(4'b0001);
            if (p == 1) evt(4'b0100);
            if (p == 2) evt(4'b0010);
            if (p == 3) begin evt(4'b0100); evt(4'b0010); end
            check("R8 R9 R10 prestate", status_o, exp_byte());
            {ev_wdt_clr, ev_sleep, ev_wdt_to, ev_pwrup} = e[3:0];
            wr_en = 1; wr_data = 8'hFF;
            if (e[0])      tg = "R8 power-up";
            else if (e[1]) tg = "R9 wdt time-out";
            else if (e[2]) tg = "R10 sleep";
            else if (e[3]) tg = "R11 wdt clear";
            else           tg = "R7 write only";
            step();
            idle();
            check(tg, status_o, exp_byte());
         end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule